// File: doc/BRIEF.md
# Alarm-Started Periodic Pulse Generator

This block drives up to three periodic pulse outputs from a free-running time value supplied at its input. Nothing happens on a channel until one of two 64-bit alarm comparators sees the current time reach its programmed value. The alarm starts every enabled channel that selected it, raises an alarm event, and disarms itself until software writes it again.

Once started, a channel keeps a 33-bit remaining-time counter. It loads its 32-bit interval register, then loses one integer clock step for every timer tick. When fewer than one step remains, it adds the interval back and starts a new pulse. The interval register therefore holds the wanted period minus one step. A pulse stays high for a 5-bit count of output-clock ticks, where the output clock is the timer tick divided by a programmable prescaler. A mode bit turns the channel into a toggling square wave instead. Each channel start or reload sets a per-channel event bit. Software clears event bits by writing one to them.

All settings sit behind a simple word-addressed register port. The address map is:

| Address | Register |
|---------|----------|
| 0 | Control word |
| 1 | Events |
| 2 | Prescaler |
| 3 | Step |
| 4 / 5 | Alarm 0, low / high word |
| 6 / 7 | Alarm 1, low / high word |
| 8 to 10 | Channel interval |

Top module: `alarm_pulse_gen`

## Requirements
- R1: After reset all pulse outputs are low, the control word (address 0) reads 0x00808080 (every channel disabled), the events (address 1) read 0, the prescaler (address 2) reads 2, the step (address 3) reads 1, every interval register (addresses 8..10) reads 0xFFFFFFFF, and every alarm word reads 0xFFFFFFFF.
- R2: Alarm a (low word at address 4+2a, high word at 5+2a) fires in the first cycle where it is armed and now_i >= its value. Firing sets event bit 16+a and disarms the alarm until its high word is written again. Writing the high word arms the alarm unless the full 64-bit value is all ones; an all-ones alarm never fires.
- R3: A low-word alarm write only fills a staging word. The committed alarm value, as read back at either address, changes only when the high word is written, and then the staged low word and the written high word take effect together.
- R4: Channel i's control byte sits at bits 8i+7..8i. Bit 7 is the disable bit, bit 6 the toggle mode, bit 5 the alarm select (1 = alarm 1), and bits 4..0 the width. An enabled channel that is not running stays idle with its output low until its selected alarm fires. It then starts on that same clock edge.
- R5: A running channel loads its remaining time from its interval register at start. On each tick_i it either subtracts the step (address 3), or, when the remaining time is less than the step, adds the interval and begins a new pulse. The period is therefore (interval + step) / step ticks.
- R6: In pulse mode a started pulse is high for exactly width output-clock ticks after it begins, and a width of 0 gives no high level. The output clock fires on a tick_i where the prescaler count has reached prescaler-1, and a prescaler of 0 acts as 1.
- R7: Every start or reload of channel i sets event bit 7-i. Writing a one to an event bit clears it. A new event in the same cycle wins over the clear.
- R8: While a channel's disable bit is set, its output is low from the edge the control write takes effect. Its run state is dropped, so any pending start is cancelled. After re-enabling, the channel waits for a fresh alarm firing.
- R9: With mode bit 6 set, the channel output toggles at every start and reload instead of producing a width-limited pulse.
- R10: A channel whose interval register holds 0xFFFFFFFF does not start when its alarm fires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Timer tick; the time advances by one step |
| now_i | input | 64 | Current time value |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 4 | Register read address |
| rd_data_o | output | 32 | Register read data (combinational) |
| pulse_o | output | 3 | Channel pulse outputs |

## Verification
The hardest state to reach from the ports is a channel that was enabled and waiting, had its pending start cancelled by a disable, and is then re-enabled after its alarm has already fired. The stimulus reaches it by rewriting alarm 0 to fire shortly afterwards and disabling channel 0 before that firing. It re-enables the channel only after the alarm event has been raised, then watches for the output to stay low while a sibling channel on the same alarm starts toggling. Irregular tick gaps and a prescaler change in mid-run make the pulse widths and reload points fall at uneven cycles. A behavioural model in the bench tracks every one of them.

// File: rtl/alarm_pulse_gen.sv
module alarm_pulse_gen #(
  parameter int NCH      = 3,
  parameter int NALM     = 2,
  parameter int STEPW    = 10,
  parameter int PRSW     = 8,
  parameter int AW       = 4,
  parameter int STEP_RST = 1,
  parameter int PRSC_RST = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic [63:0]     now_i,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [31:0]     wr_data_i,
  input  logic [AW-1:0]   rd_addr_i,
  output logic [31:0]     rd_data_o,
  output logic [NCH-1:0]  pulse_o
);
  localparam int A_CTRL = 0;
  localparam int A_EVT  = 1;
  localparam int A_PRSC = 2;
  localparam int A_STEP = 3;
  localparam int A_ALM  = 4;
  localparam int A_IVAL = A_ALM + 2 * NALM;
  localparam logic [31:0] CMASK = 32'((64'h1 << (8 * NCH)) - 1);

  function automatic logic [31:0] ctrl_init();
    logic [31:0] v = '0;
    for (int k = 0; k < NCH; k++) v[8*k+7] = 1'b1;
    return v;
  endfunction

  logic [31:0]            ctrl_q, event_q, ev_set;
  logic [PRSW-1:0]        presc_q, pcnt_q, psc_eff;
  logic [STEPW-1:0]       step_q;
  logic [NALM-1:0][63:0]  alm_q;
  logic [NALM-1:0][31:0]  stage_q;
  logic [NALM-1:0]        armed_q, fire;
  logic [NCH-1:0][31:0]   ival_q;
  logic [NCH-1:0]         run_q, out_q, hit;
  logic                   otick;

  assign psc_eff = (presc_q == '0) ? PRSW'(1) : presc_q;
  assign otick   = tick_i && (pcnt_q >= psc_eff - PRSW'(1));

  function automatic logic is_wr(input int a);
    return wr_en_i && (wr_addr_i == AW'(a));
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) pcnt_q <= '0;
    else if (tick_i) pcnt_q <= otick ? '0 : pcnt_q + PRSW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= ctrl_init();
      presc_q <= PRSW'(PRSC_RST);
      step_q  <= STEPW'(STEP_RST);
    end else begin
      if (is_wr(A_CTRL)) ctrl_q  <= wr_data_i & CMASK;
      if (is_wr(A_PRSC)) presc_q <= wr_data_i[PRSW-1:0];
      if (is_wr(A_STEP)) step_q  <= wr_data_i[STEPW-1:0];
    end
  end

  for (genvar a = 0; a < NALM; a++) begin : g_alm
    assign fire[a] = armed_q[a] && (now_i >= alm_q[a]);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        alm_q[a]   <= '1;
        stage_q[a] <= '1;
        armed_q[a] <= 1'b0;
      end else begin
        if (is_wr(A_ALM + 2 * a)) stage_q[a] <= wr_data_i;
        if (is_wr(A_ALM + 2 * a + 1)) begin
          alm_q[a]   <= {wr_data_i, stage_q[a]};
          armed_q[a] <= ({wr_data_i, stage_q[a]} != '1);
        end else if (fire[a]) begin
          armed_q[a] <= 1'b0;
        end
      end
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic        dis, mode, sel, start, reload;
    logic [4:0]  wid, wcnt_q;
    logic [32:0] cnt_q;

    assign dis    = ctrl_q[8*i+7];
    assign mode   = ctrl_q[8*i+6];
    assign sel    = ctrl_q[8*i+5];
    assign wid    = ctrl_q[8*i+4 -: 5];
    assign start  = !dis && !run_q[i] && fire[sel] && (ival_q[i] != '1);
    assign reload = run_q[i] && tick_i && (cnt_q < 33'(step_q));
    assign hit[i] = start || reload;
    assign pulse_o[i] = out_q[i] && !dis;

    always_ff @(posedge clk) begin
      if (!rst_n) ival_q[i] <= '1;
      else if (is_wr(A_IVAL + i)) ival_q[i] <= wr_data_i;
    end

    always_ff @(posedge clk) begin
      if (!rst_n || dis) begin
        run_q[i] <= 1'b0;
        out_q[i] <= 1'b0;
        cnt_q    <= '0;
        wcnt_q   <= '0;
      end else begin
        if (start) begin
          run_q[i] <= 1'b1;
          cnt_q    <= {1'b0, ival_q[i]};
        end else if (run_q[i] && tick_i) begin
          cnt_q <= reload ? cnt_q + {1'b0, ival_q[i]} : cnt_q - 33'(step_q);
        end
        if (hit[i]) begin
          if (mode) out_q[i] <= !out_q[i];
          else begin
            out_q[i] <= (wid != '0);
            wcnt_q   <= wid;
          end
        end else if (!mode && out_q[i] && otick) begin
          wcnt_q <= wcnt_q - 5'd1;
          if (wcnt_q <= 5'd1) out_q[i] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    ev_set = '0;
    for (int a = 0; a < NALM; a++) ev_set[16+a] = fire[a];
    for (int i = 0; i < NCH; i++) ev_set[7-i] = hit[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) event_q <= '0;
    else event_q <= (event_q & ~(is_wr(A_EVT) ? wr_data_i : 32'h0)) | ev_set;
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == AW'(A_CTRL)) rd_data_o = ctrl_q;
    if (rd_addr_i == AW'(A_EVT))  rd_data_o = event_q;
    if (rd_addr_i == AW'(A_PRSC)) rd_data_o = 32'(presc_q);
    if (rd_addr_i == AW'(A_STEP)) rd_data_o = 32'(step_q);
    for (int a = 0; a < NALM; a++) begin
      if (rd_addr_i == AW'(A_ALM + 2 * a))     rd_data_o = alm_q[a][31:0];
      if (rd_addr_i == AW'(A_ALM + 2 * a + 1)) rd_data_o = alm_q[a][63:32];
    end
    for (int i = 0; i < NCH; i++)
      if (rd_addr_i == AW'(A_IVAL + i)) rd_data_o = ival_q[i];
  end
endmodule

// File: rtl/alarm_pulse_chk.sv
module alarm_pulse_chk #(
  parameter int NCH  = 3,
  parameter int NALM = 2,
  parameter int AW   = 4,
  parameter int AALM = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en_i,
  input logic [AW-1:0]         wr_addr_i,
  input logic [NCH-1:0]        pulse_o,
  input logic [NCH-1:0]        run_q,
  input logic [NALM-1:0]       fire,
  input logic [NALM-1:0]       armed_q,
  input logic [31:0]           event_q,
  input logic [NALM-1:0][63:0] alm_q
);
  for (genvar a = 0; a < NALM; a++) begin : g_a
    a_r2_fire_disarms: assert property (@(posedge clk) disable iff (!rst_n)
      fire[a] && !(wr_en_i && wr_addr_i == AW'(AALM + 2 * a + 1)) |=> !armed_q[a]);
    a_r2_fire_sets_event: assert property (@(posedge clk) disable iff (!rst_n)
      fire[a] |=> event_q[16+a]);
    a_r3_hold_until_high: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en_i && wr_addr_i == AW'(AALM + 2 * a + 1)) |=> $stable(alm_q[a]));
  end
  for (genvar i = 0; i < NCH; i++) begin : g_c
    a_r7_rise_flags_event: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse_o[i]) |-> event_q[7-i]);
    a_r4_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q[i] |-> !pulse_o[i]);
  end
endmodule

bind alarm_pulse_gen alarm_pulse_chk #(.NCH(NCH), .NALM(NALM), .AW(AW), .AALM(A_ALM)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .pulse_o(pulse_o), .run_q(run_q), .fire(fire), .armed_q(armed_q),
  .event_q(event_q), .alm_q(alm_q));

// File: tb/sim_alarm_pulse_gen.sv
`timescale 1ns/1ps
module sim_alarm_pulse_gen;
  logic        clk = 0, rst_n = 0, tick = 0, wr_en = 0;
  logic [63:0] now = 0;
  logic [3:0]  wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic [2:0]  pulse;
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0, live = 0;
  string cur_req = "R1";

  alarm_pulse_gen u0 (.clk(clk), .rst_n(rst_n), .tick_i(tick), .now_i(now),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .pulse_o(pulse));

  always #2.5 clk = ~clk;

  // reference model
  logic [31:0] m_ctrl, m_ev, m_ival[3], m_sh[2];
  logic [63:0] m_alm[2];
  bit          m_arm[2], m_run[3], m_out[3];
  int          m_presc, m_step, m_pcnt, m_w[3];
  longint      m_cnt[3];

  function automatic logic [31:0] m_read(input int a);
    case (a)
      0: return m_ctrl;
      1: return m_ev;
      2: return 32'(m_presc);
      3: return 32'(m_step);
      4: return m_alm[0][31:0];
      5: return m_alm[0][63:32];
      6: return m_alm[1][31:0];
      7: return m_alm[1][63:32];
      8, 9, 10: return m_ival[a-8];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 32'h00808080; m_ev = 0; m_presc = 2; m_step = 1; m_pcnt = 0;
      for (int k = 0; k < 2; k++) begin m_alm[k] = '1; m_sh[k] = '1; m_arm[k] = 0; end
      for (int k = 0; k < 3; k++) begin
        m_ival[k] = '1; m_run[k] = 0; m_out[k] = 0; m_cnt[k] = 0; m_w[k] = 0;
      end
    end else begin
      bit f[2], ot, hit;
      int psc;
      logic [31:0] setb;
      setb = 0;
      for (int a = 0; a < 2; a++) begin
        f[a] = m_arm[a] && now >= m_alm[a];
        if (f[a]) begin setb[16+a] = 1; m_arm[a] = 0; end
      end
      psc = (m_presc == 0) ? 1 : m_presc;
      ot = tick && (m_pcnt >= psc - 1);
      for (int i = 0; i < 3; i++) begin
        bit dis, md, sl, st, rl;
        int wd;
        dis = m_ctrl[8*i+7]; md = m_ctrl[8*i+6]; sl = m_ctrl[8*i+5];
        wd = int'(m_ctrl[8*i +: 5]);
        if (dis) begin
          m_run[i] = 0; m_out[i] = 0; m_cnt[i] = 0; m_w[i] = 0;
        end else begin
          st = !m_run[i] && f[sl] && m_ival[i] != 32'hFFFFFFFF;
          rl = m_run[i] && tick && m_cnt[i] < m_step;
          hit = st || rl;
          if (st) begin m_run[i] = 1; m_cnt[i] = longint'(m_ival[i]); end
          else if (m_run[i] && tick) m_cnt[i] = rl ? m_cnt[i] + longint'(m_ival[i]) : m_cnt[i] - m_step;
          if (hit) begin
            setb[7-i] = 1;
            if (md) m_out[i] = !m_out[i];
            else begin m_out[i] = (wd != 0); m_w[i] = wd; end
          end else if (!md && m_out[i] && ot) begin
            if (m_w[i] <= 1) m_out[i] = 0;
            m_w[i] = (m_w[i] - 1) & 31;
          end
        end
      end
      if (tick) m_pcnt = ot ? 0 : (m_pcnt + 1) & 255;
      m_ev = (m_ev & ~((wr_en && wr_addr == 1) ? wr_data : 32'h0)) | setb;
      if (wr_en) case (wr_addr)
        0: m_ctrl = wr_data & 32'h00FFFFFF;
        2: m_presc = int'(wr_data[7:0]);
        3: m_step = int'(wr_data[9:0]);
        4: m_sh[0] = wr_data;
        5: begin m_alm[0] = {wr_data, m_sh[0]}; m_arm[0] = (m_alm[0] != '1); end
        6: m_sh[1] = wr_data;
        7: begin m_alm[1] = {wr_data, m_sh[1]}; m_arm[1] = (m_alm[1] != '1); end
        8, 9, 10: m_ival[wr_addr-8] = wr_data;
        default: ;
      endcase
    end
  end

  always @(posedge clk) if (tick) now <= now + 64'd8;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    tick <= rst_n && (cyc % 7 != 6);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (live)
    for (int i = 0; i < 3; i++) chk(cur_req, 32'(pulse[i]), 32'(m_out[i] && !m_ctrl[8*i+7]));

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = 4'(a); wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic rd_lit(input string req, input int a, input logic [31:0] exp);
    @(negedge clk); rd_addr = 4'(a); #1; chk(req, rd_data, exp);
  endtask
  task automatic rd_mdl(input string req, input int a);
    @(negedge clk); rd_addr = 4'(a); #1; chk(req, rd_data, m_read(a));
  endtask
  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [63:0] t;
    int togg;
    logic p2;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", 32'(pulse), 0);
    rd_lit("R1", 0, 32'h00808080); rd_lit("R1", 1, 0); rd_lit("R1", 2, 2);
    rd_lit("R1", 3, 1); rd_lit("R1", 8, '1); rd_lit("R1", 10, '1); rd_lit("R1", 5, '1);
    live = 1;
    cur_req = "R5";
    wr(3, 8); wr(2, 2); wr(8, 32); wr(9, 56);
    wr(0, 32'h00402203);
    cur_req = "R3";
    wr(4, 800);
    rd_lit("R3", 4, '1);
    wr(5, 0);
    rd_lit("R3", 4, 800); rd_lit("R3", 5, 0);
    cur_req = "R6";
    run(150);
    chk("R2", 32'(pulse[1]), 0);
    chk("R10", 32'(pulse[2]), 0);
    rd_lit("R2", 1, m_ev | 32'h00010000);
    rd_mdl("R7", 1);
    cur_req = "R7";
    wr(1, 32'h00010080);
    run(60);
    @(negedge clk); rd_addr = 1; #1; chk("R2", 32'(rd_data[16]), 0);
    rd_mdl("R7", 1);
    cur_req = "R8";
    wr(0, 32'h00402283);
    for (int k = 0; k < 20; k++) begin @(negedge clk); chk("R8", 32'(pulse[0]), 0); end
    wr(0, 32'h00402203);
    for (int k = 0; k < 40; k++) begin @(negedge clk); chk("R4", 32'(pulse[0]), 0); end
    cur_req = "R4";
    t = now + 240;
    wr(6, t[31:0]); wr(7, t[63:32]);
    run(120);
    rd_mdl("R4", 1);
    cur_req = "R9";
    wr(2, 3); wr(10, 24);
    wr(0, 32'h00402283);
    t = now + 160;
    wr(4, t[31:0]); wr(5, t[63:32]);
    run(50);
    wr(0, 32'h00402203);
    togg = 0; p2 = pulse[2];
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      chk("R8", 32'(pulse[0]), 0);
      if (pulse[2] !== p2) togg++;
      p2 = pulse[2];
    end
    chk("R9", 32'(togg > 2), 1);
    for (int a = 0; a < 11; a++) rd_mdl("R5", a);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule